// File: doc/BRIEF.md
# Pipeline Interlock and Bypass Control

This block decides, cycle by cycle, whether a five-stage in-order integer pipeline must hold its front end and which bypass path each operand consumer should take. It receives register indices and write/load flags from the decode stage, the execute stage, the EX/MEM latch and the MEM/WB latch. From these it produces one stall strobe and a set of two-bit bypass selects. The stall strobe holds the PC and the IF/ID latch and loads a no-op into ID/EX. The selects cover the two ALU operands in execute, store data in execute, and the two compare operands of a branch that resolves in decode.

Bypassing can be turned off. The mode is taken from `fwdEnable` only on a clock edge while synchronous reset is active, so an in-flight instruction stream never sees the rules change. With bypassing off, a reader waits in decode until its producer has reached write-back. The register file writes in the first half of a cycle and reads in the second, so a write-back producer needs no stall in either mode.

Top module: `hazard_ctrl_top`

## Requirements
- R1: The mode register takes the value of `fwdEnable` on a rising clock edge with `rstN` low and holds it at every other edge; `fwdEnable` has no other effect.
- R2: Register index 0 never causes a stall and never produces a nonzero bypass select.
- R3: With bypassing off, `stall` is 1 when a used decode source (`idUsesRs1`/`idRs1`, `idUsesRs2`/`idRs2`) equals a nonzero written destination in execute (`exWe`, `exRd`) or in EX/MEM (`memWe`, `memRd`), and every select is 00.
- R4: With bypassing on, a non-branch decode instruction stalls only when a used source equals the destination of a load in execute (`exWe` and `exIsLoad`).
- R5: With bypassing on, `exSelA`/`exSelB` give 10 when `exRs1`/`exRs2` equals the EX/MEM destination, otherwise 01 when it equals the MEM/WB destination (`wbWe`, `wbRd`), otherwise 00; EX/MEM wins over MEM/WB.
- R6: `storeSel` follows the R5 encoding for `exRs2` when `exIsStore` is 1 and is 00 when `exIsStore` is 0.
- R7: With bypassing on, a decode branch (`idIsBranch`) stalls when a used source equals any written destination in execute, or equals the EX/MEM destination while `memIsLoad` is 1.
- R8: With bypassing on, `brSelA`/`brSelB` follow the R5 encoding for `idRs1`/`idRs2` when `idIsBranch` and the matching use flag are 1, and are 00 otherwise.
- R9: A decode source whose use flag is 0 never causes a stall.
- R10: With bypassing off, a source that matches only the MEM/WB destination causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; mode is sampled here |
| fwdEnable | input | 1 | Bypass enable, sampled during reset |
| idRs1 | input | 5 | Decode source 1 index |
| idRs2 | input | 5 | Decode source 2 index |
| idUsesRs1 | input | 1 | Decode instruction reads source 1 |
| idUsesRs2 | input | 1 | Decode instruction reads source 2 |
| idIsBranch | input | 1 | Decode instruction is a branch compared in decode |
| exRs1 | input | 5 | Execute source 1 index |
| exRs2 | input | 5 | Execute source 2 / store data index |
| exIsStore | input | 1 | Execute instruction is a store |
| exRd | input | 5 | Execute destination index |
| exWe | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| memRd | input | 5 | EX/MEM destination index |
| memWe | input | 1 | EX/MEM writes a register |
| memIsLoad | input | 1 | EX/MEM holds a load |
| wbRd | input | 5 | MEM/WB destination index |
| wbWe | input | 1 | MEM/WB writes a register |
| stall | output | 1 | Hold PC and IF/ID, insert no-op into ID/EX |
| exSelA | output | 2 | Execute operand A bypass select |
| exSelB | output | 2 | Execute operand B bypass select |
| storeSel | output | 2 | Store data bypass select |
| brSelA | output | 2 | Branch compare operand A select |
| brSelB | output | 2 | Branch compare operand B select |

## Verification
A decode-stage interlock and an execute-stage bypass often fall in the same cycle: a load sits in execute while its consumer waits in decode, and an older ALU result is at the same time bypassed into execute or into a branch compare. The random phase draws register indices from a set of four values, zero included, so matches between stages happen often and several stages can hold the same destination at once. In every cycle the stall and all five selects are compared together with a bench model, in both modes.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    BYP_RF  = 2'd0,
    BYP_WB  = 2'd1,
    BYP_MEM = 2'd2
  } bypSel_e;

  typedef struct packed {
    logic bypassOn;
    logic stall;
  } ctrlStrobes_t;
endpackage

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fwdEnable,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idUsesRs1,
  input  logic             idUsesRs2,
  input  logic             idIsBranch,
  input  logic [REG_W-1:0] exRd,
  input  logic             exWe,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] memRd,
  input  logic             memWe,
  input  logic             memIsLoad,
  output ctrlStrobes_t     strobes,
  output logic             modeQ
);
  localparam int NUM_SRC = 2;

  logic [REG_W-1:0] idSrc [NUM_SRC];
  logic [NUM_SRC-1:0] idUse;
  logic [NUM_SRC-1:0] blockFwd;
  logic [NUM_SRC-1:0] blockNoFwd;

  assign idSrc[0] = idRs1;
  assign idSrc[1] = idRs2;
  assign idUse    = {idUsesRs2, idUsesRs1};

  // mode is sampled only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= fwdEnable;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic live;
    logic needEx;
    logic needMem;
    assign live    = idUse[i] && (idSrc[i] != '0);
    assign needEx  = live && exWe && (exRd == idSrc[i]);
    assign needMem = live && memWe && (memRd == idSrc[i]);
    assign blockNoFwd[i] = needEx | needMem;
    assign blockFwd[i]   = idIsBranch ? (needEx | (needMem & memIsLoad))
                                      : (needEx & exIsLoad);
  end

  assign strobes.bypassOn = modeQ;
  assign strobes.stall    = modeQ ? (|blockFwd) : (|blockNoFwd);
endmodule

// File: rtl/byp_pick.sv
module byp_pick
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             en,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] memRd,
  input  logic             memWe,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbWe,
  output bypSel_e          sel
);
  logic nz;
  assign nz = (src != '0);

  always_comb begin
    sel = BYP_RF;
    if (en && nz) begin
      if (memWe && memRd == src)     sel = BYP_MEM;
      else if (wbWe && wbRd == src)  sel = BYP_WB;
    end
  end
endmodule

// File: rtl/hzd_bypass.sv
module hzd_bypass
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  ctrlStrobes_t     strobes,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idUsesRs1,
  input  logic             idUsesRs2,
  input  logic             idIsBranch,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic             exIsStore,
  input  logic [REG_W-1:0] memRd,
  input  logic             memWe,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbWe,
  output bypSel_e          exSelA,
  output bypSel_e          exSelB,
  output bypSel_e          storeSel,
  output bypSel_e          brSelA,
  output bypSel_e          brSelB
);
  localparam int NUM_PICK = 5;

  logic [REG_W-1:0] pickSrc [NUM_PICK];
  logic [NUM_PICK-1:0] pickEn;
  bypSel_e pickSel [NUM_PICK];

  assign pickSrc[0] = exRs1;
  assign pickSrc[1] = exRs2;
  assign pickSrc[2] = exRs2;
  assign pickSrc[3] = idRs1;
  assign pickSrc[4] = idRs2;

  assign pickEn[0] = strobes.bypassOn;
  assign pickEn[1] = strobes.bypassOn;
  assign pickEn[2] = strobes.bypassOn & exIsStore;
  assign pickEn[3] = strobes.bypassOn & idIsBranch & idUsesRs1;
  assign pickEn[4] = strobes.bypassOn & idIsBranch & idUsesRs2;

  for (genvar i = 0; i < NUM_PICK; i++) begin : g_pick
    byp_pick #(.REG_W(REG_W)) u_pick (
      .en    (pickEn[i]),
      .src   (pickSrc[i]),
      .memRd (memRd),
      .memWe (memWe),
      .wbRd  (wbRd),
      .wbWe  (wbWe),
      .sel   (pickSel[i])
    );
  end

  assign exSelA   = pickSel[0];
  assign exSelB   = pickSel[1];
  assign storeSel = pickSel[2];
  assign brSelA   = pickSel[3];
  assign brSelB   = pickSel[4];
endmodule

// File: rtl/hazard_ctrl_top.sv
module hazard_ctrl_top
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fwdEnable,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idUsesRs1,
  input  logic             idUsesRs2,
  input  logic             idIsBranch,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic             exIsStore,
  input  logic [REG_W-1:0] exRd,
  input  logic             exWe,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] memRd,
  input  logic             memWe,
  input  logic             memIsLoad,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbWe,
  output logic             stall,
  output logic [1:0]       exSelA,
  output logic [1:0]       exSelB,
  output logic [1:0]       storeSel,
  output logic [1:0]       brSelA,
  output logic [1:0]       brSelB
);
  ctrlStrobes_t strobes;
  logic modeQ;
  bypSel_e selA, selB, selSt, selBa, selBb;

  hzd_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk, .rstN, .fwdEnable,
    .idRs1, .idRs2, .idUsesRs1, .idUsesRs2, .idIsBranch,
    .exRd, .exWe, .exIsLoad,
    .memRd, .memWe, .memIsLoad,
    .strobes, .modeQ
  );

  hzd_bypass #(.REG_W(REG_W)) u_bypass (
    .strobes,
    .idRs1, .idRs2, .idUsesRs1, .idUsesRs2, .idIsBranch,
    .exRs1, .exRs2, .exIsStore,
    .memRd, .memWe, .wbRd, .wbWe,
    .exSelA(selA), .exSelB(selB), .storeSel(selSt),
    .brSelA(selBa), .brSelB(selBb)
  );

  assign stall    = strobes.stall;
  assign exSelA   = selA;
  assign exSelB   = selB;
  assign storeSel = selSt;
  assign brSelA   = selBa;
  assign brSelB   = selBb;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             fwdEnable,
  input logic             modeQ,
  input logic [REG_W-1:0] idRs1,
  input logic [REG_W-1:0] idRs2,
  input logic             idUsesRs1,
  input logic             idIsBranch,
  input logic [REG_W-1:0] exRs1,
  input logic [REG_W-1:0] exRd,
  input logic             exWe,
  input logic             exIsLoad,
  input logic             exIsStore,
  input logic [REG_W-1:0] memRd,
  input logic             memWe,
  input logic             stall,
  input logic [1:0]       exSelA,
  input logic [1:0]       exSelB,
  input logic [1:0]       storeSel,
  input logic [1:0]       brSelA,
  input logic [1:0]       brSelB
);
  a_r1_mode_holds: assert property (@(posedge clk) disable iff (!rstN)
    (fwdEnable != modeQ) |=> (modeQ == $past(modeQ)));

  a_r2_zero_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    (idRs1 == '0 && idRs2 == '0) |-> !stall);

  a_r3_off_no_bypass: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ |-> (exSelA == 2'd0 && exSelB == 2'd0 && storeSel == 2'd0
                && brSelA == 2'd0 && brSelB == 2'd0));

  a_r4_load_use_stall: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && exWe && exIsLoad && exRd != '0 && idUsesRs1 && idRs1 == exRd)
      |-> stall);

  a_r5_mem_priority: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && memWe && memRd != '0 && exRs1 == memRd) |-> exSelA == 2'd2);

  a_r6_store_idle: assert property (@(posedge clk) disable iff (!rstN)
    !exIsStore |-> storeSel == 2'd0);

  a_r8_branch_idle: assert property (@(posedge clk) disable iff (!rstN)
    !idIsBranch |-> (brSelA == 2'd0 && brSelB == 2'd0));
endmodule

bind hazard_ctrl_top hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk, .rstN, .fwdEnable, .modeQ,
  .idRs1, .idRs2, .idUsesRs1, .idIsBranch,
  .exRs1, .exRd, .exWe, .exIsLoad, .exIsStore,
  .memRd, .memWe,
  .stall, .exSelA, .exSelB, .storeSel, .brSelA, .brSelB
);

// File: tb/tb_hazard_ctrl_top.sv
module tb_hazard_ctrl_top;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rstN, fwdEnable;
  logic [RW-1:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic idUsesRs1, idUsesRs2, idIsBranch, exIsStore, exWe, exIsLoad;
  logic memWe, memIsLoad, wbWe;
  logic stall;
  logic [1:0] exSelA, exSelB, storeSel, brSelA, brSelB;

  int nChecks = 0;
  int nFails = 0;
  logic benchMode;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hazard_ctrl_top #(.REG_W(RW)) dut (.*);

  function automatic logic [1:0] expSel(logic on, logic [RW-1:0] s);
    if (!on || s == 0) return 2'd0;
    if (memWe && memRd == s) return 2'd2;
    if (wbWe && wbRd == s) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic expStall();
    logic e1, e2, m1, m2;
    e1 = idUsesRs1 && idRs1 != 0 && exWe && exRd == idRs1;
    e2 = idUsesRs2 && idRs2 != 0 && exWe && exRd == idRs2;
    m1 = idUsesRs1 && idRs1 != 0 && memWe && memRd == idRs1;
    m2 = idUsesRs2 && idRs2 != 0 && memWe && memRd == idRs2;
    if (!benchMode) return e1 | e2 | m1 | m2;
    if (idIsBranch) return e1 | e2 | (memIsLoad & (m1 | m2));
    return exIsLoad & (e1 | e2);
  endfunction

  task automatic checkAll(string tag);
    logic [10:0] act, exp;
    #1;
    exp = {expStall(), expSel(benchMode, exRs1), expSel(benchMode, exRs2),
           expSel(benchMode && exIsStore, exRs2),
           expSel(benchMode && idIsBranch && idUsesRs1, idRs1),
           expSel(benchMode && idIsBranch && idUsesRs2, idRs2)};
    act = {stall, exSelA, exSelB, storeSel, brSelA, brSelB};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b (stall,exA,exB,st,brA,brB)", tag, act, exp);
    end
  endtask

  task automatic idle();
    {idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd} = '0;
    {idUsesRs1, idUsesRs2, idIsBranch, exIsStore, exWe, exIsLoad} = '0;
    {memWe, memIsLoad, wbWe} = '0;
  endtask

  task automatic doReset(logic m);
    @(negedge clk);
    rstN = 1'b0; fwdEnable = m;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    benchMode = m;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b1; fwdEnable = 1'b1; benchMode = 1'b1;
    idle();
    doReset(1'b1);
    checkAll("R1 reset state idle");

    // R5 ALU to ALU: producer in EX/MEM, consumer in EX, no stall
    @(negedge clk); idle();
    memRd = 5'd3; memWe = 1; exRs1 = 5'd3; exRs2 = 5'd3; wbRd = 5'd3; wbWe = 1;
    checkAll("R5 mem over wb priority");
    @(negedge clk); idle();
    wbRd = 5'd7; wbWe = 1; exRs2 = 5'd7;
    checkAll("R5 wb bypass");

    // R4 load use stall; R5 alu in EX no stall
    @(negedge clk); idle();
    exRd = 5'd4; exWe = 1; exIsLoad = 1; idRs1 = 5'd4; idUsesRs1 = 1;
    checkAll("R4 load use stall");
    @(negedge clk); exIsLoad = 0;
    checkAll("R5 alu dependent no stall");

    // R9 unused source
    @(negedge clk); exIsLoad = 1; idUsesRs1 = 0;
    checkAll("R9 unused source no stall");

    // R2 register zero
    @(negedge clk); idle();
    exRd = 0; exWe = 1; exIsLoad = 1; idRs1 = 0; idUsesRs1 = 1;
    memRd = 0; memWe = 1; exRs1 = 0; idIsBranch = 1;
    checkAll("R2 zero index ignored");

    // R6 store data bypass
    @(negedge clk); idle();
    exIsStore = 1; exRs2 = 5'd9; memRd = 5'd9; memWe = 1;
    checkAll("R6 store bypass");
    @(negedge clk); exIsStore = 0;
    checkAll("R6 non-store select zero");

    // R7/R8 branch cases
    @(negedge clk); idle();
    idIsBranch = 1; idUsesRs1 = 1; idRs1 = 5'd5; exRd = 5'd5; exWe = 1;
    checkAll("R7 branch after alu stalls");
    @(negedge clk); idle();
    idIsBranch = 1; idUsesRs1 = 1; idRs1 = 5'd5; memRd = 5'd5; memWe = 1; memIsLoad = 1;
    checkAll("R7 branch load in mem stalls");
    @(negedge clk); memIsLoad = 0;
    checkAll("R8 branch alu mem bypass");
    @(negedge clk); idle();
    idIsBranch = 1; idUsesRs2 = 1; idRs2 = 5'd6; wbRd = 5'd6; wbWe = 1;
    checkAll("R8 branch wb bypass");

    // R1 fwdEnable changed without reset has no effect
    @(negedge clk); idle(); fwdEnable = 1'b0;
    repeat (3) @(negedge clk);
    exRd = 5'd2; exWe = 1; idRs1 = 5'd2; idUsesRs1 = 1; exRs1 = 5'd8; memRd = 5'd8; memWe = 1;
    checkAll("R1 mode unchanged without reset");

    // R3/R10 bypass off
    idle();
    doReset(1'b0);
    exRd = 5'd2; exWe = 1; idRs1 = 5'd2; idUsesRs1 = 1;
    checkAll("R3 off ex dependence stalls");
    @(negedge clk); idle();
    memRd = 5'd2; memWe = 1; idRs2 = 5'd2; idUsesRs2 = 1; exRs1 = 5'd2;
    checkAll("R3 off mem dependence stalls selects zero");
    @(negedge clk); idle();
    wbRd = 5'd2; wbWe = 1; idRs1 = 5'd2; idUsesRs1 = 1;
    checkAll("R10 off wb dependence no stall");

    // random mix in both modes, narrow index space
    for (int pass = 0; pass < 2; pass++) begin
      idle();
      doReset(pass == 0);
      for (int n = 0; n < 1500; n++) begin
        @(negedge clk);
        idRs1 = RW'($urandom_range(0, 3)); idRs2 = RW'($urandom_range(0, 3));
        exRs1 = RW'($urandom_range(0, 3)); exRs2 = RW'($urandom_range(0, 3));
        exRd = RW'($urandom_range(0, 3)); memRd = RW'($urandom_range(0, 3));
        wbRd = RW'($urandom_range(0, 3));
        {idUsesRs1, idUsesRs2, idIsBranch, exIsStore, exWe, exIsLoad,
         memWe, memIsLoad, wbWe} = 9'($urandom);
        checkAll(benchMode ? "R4 R5 R6 R7 R8 random on" : "R3 R10 random off");
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule